// File: doc/BRIEF.md
# Memory Ordering Issue Gate

This block sits beside the memory queue of an out-of-order core and decides, for every queued memory operation, whether the cache port may accept it now. The gate also decides whether a load may take its value from an older store inside the queue. It holds a small window of operations in program order, with the oldest at slot 0. Each slot is a load, a store or a fence. The cache side reports completion with a one-cycle pulse on the slot's globally-performed input. The gate latches that pulse until the operation leaves the window.

Three ordering disciplines are selectable. Sequential mode serialises every access behind the completion of all older accesses and never forwards. Processor/total-store mode orders loads among themselves and keeps stores in order behind everything older, while loads may pass older stores and always forward. Relaxed mode orders nothing by default. Fences supply ordering in relaxed mode, each with a four-bit kind mask or a full-drain flag. Acquire and release sequences are built from these masks. An acquire is followed by a fence with LoadLoad and LoadStore set. A release is preceded by a fence with LoadStore and StoreStore set. The mode must not change while the window holds entries.

Top module: `mem_order_gate`

## Requirements
- R1: After a synchronous active-low reset the window is empty and entry_valid, issue_ok and fwd_ok are all zero.
- R2: alloc_valid appends one entry at the youngest free slot on the next clock. The kind encoding is 00 load, 01 store and 10 fence. alloc_mask bit 0 is LoadLoad, bit 1 is LoadStore, bit 2 is StoreLoad and bit 3 is StoreStore. When the window is full and nothing retires in the same cycle, the allocation is ignored.
- R3: A gp_pulse on a valid slot sets that entry's performed flag. The flag persists and moves with the entry when older entries retire.
- R4: retire_req removes slot 0 on the next clock only if that entry is a fence or has performed. Otherwise the request is ignored and the window is unchanged. Younger entries shift one slot toward slot 0.
- R5: In sequential mode (mode 00), a load or store is issuable only when every older load and store has performed. Fence entries have no effect.
- R6: In sequential mode, fwd_ok is zero for every slot.
- R7: In processor/total-store mode (mode 01), a load is issuable when every older load has performed, and a store is issuable when every older load and store has performed. Fence entries have no effect.
- R8: In processor/total-store mode, fwd_ok is one for every valid load.
- R9: In relaxed mode (mode 10), a younger load is blocked by an older fence in two cases. LoadLoad blocks it while a load older than that fence has not performed. StoreLoad blocks it while a store older than that fence has not performed. For a younger store, LoadStore and StoreStore play the same two roles.
- R10: In relaxed mode, a fence with alloc_drain set blocks every younger load and store while any access older than the fence has not performed, whatever its mask.
- R11: In relaxed mode, an access with no blocking older fence is issuable, and a load's fwd_ok equals its issue_ok.
- R12: Fence slots and empty slots never show issue_ok or fwd_ok.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode | input | 2 | Ordering discipline: 00 sequential, 01 processor/total-store, 10 relaxed |
| alloc_valid | input | 1 | Append a new entry |
| alloc_kind | input | 2 | Kind of the new entry: 00 load, 01 store, 10 fence |
| alloc_mask | input | 4 | Fence ordering mask: bit0 LoadLoad, bit1 LoadStore, bit2 StoreLoad, bit3 StoreStore |
| alloc_drain | input | 1 | Fence waits for all older accesses |
| retire_req | input | 1 | Request removal of slot 0 |
| gp_pulse | input | DEPTH | Per-slot globally-performed pulse |
| entry_valid | output | DEPTH | Per-slot occupancy |
| issue_ok | output | DEPTH | Per-slot permission to issue to the cache |
| fwd_ok | output | DEPTH | Per-slot permission for a load to forward from an older store |

## Verification
The sweep fills a four-entry window with every arrangement of loads, stores and fences, every performed pattern and every fence mask, plus the drain flag. This exposes a gate that lets an access overtake an unperformed predecessor, and one that lets a fence block accesses older than itself. It also exposes a gate that confuses the LoadStore and StoreLoad bits, and one that honours fences outside relaxed mode. Directed sequences cover three further faults: a retire that drops an unperformed head, a full window that accepts a fifth entry, and a performed flag that is lost or left behind when entries shift. Each of these faults shows up as the wrong occupancy or wrong issue permissions after the event.

// File: rtl/mem_order_pkg.sv
// Shared encodings and the per-slot record of the ordering gate.
package mem_order_pkg;

    typedef enum logic [1:0] {
        OP_LOAD  = 2'b00,
        OP_STORE = 2'b01,
        OP_FENCE = 2'b10,
        OP_NONE  = 2'b11
    } op_kind_e;

    typedef enum logic [1:0] {
        MD_SEQ     = 2'b00,
        MD_TSO     = 2'b01,
        MD_RELAXED = 2'b10,
        MD_RSVD    = 2'b11
    } ord_mode_e;

    // fence mask bit positions
    localparam int unsigned MB_LL = 0;
    localparam int unsigned MB_LS = 1;
    localparam int unsigned MB_SL = 2;
    localparam int unsigned MB_SS = 3;

    typedef struct packed {
        logic       valid;
        op_kind_e   kind;
        logic [3:0] mask;
        logic       drain;
        logic       done;   // globally performed
    } slot_t;

endpackage

// File: rtl/mem_order_window.sv
// Program-ordered window of memory operations, oldest in slot 0.
// Assumes: gp_pulse is indexed by the current slot position; retire only
// ever targets slot 0; allocation and retirement may share a cycle.
module mem_order_window
    import mem_order_pkg::*;
#(
    parameter int unsigned DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc_valid,
    input  op_kind_e         alloc_kind,
    input  logic [3:0]       alloc_mask,
    input  logic             alloc_drain,
    input  logic             retire_req,
    input  logic [DEPTH-1:0] gp_pulse,
    output slot_t [DEPTH-1:0] slots
);
    localparam int unsigned CW = $clog2(DEPTH + 1);

    slot_t [DEPTH-1:0] cur_q;
    slot_t [DEPTH-1:0] marked;
    slot_t [DEPTH-1:0] nxt;
    logic [CW-1:0]     cnt_q;
    logic [CW-1:0]     cnt_nxt;
    logic [CW-1:0]     wr_idx;
    logic              pop;
    logic              push;

    // head leaves only when it is a fence or has performed
    assign pop = retire_req && cur_q[0].valid &&
                 (cur_q[0].kind == OP_FENCE || cur_q[0].done);

    // slot index written by an allocation, after any shift
    assign wr_idx = cnt_q - CW'(pop);
    assign push   = alloc_valid && (wr_idx < CW'(DEPTH));

    // build the next window: latch pulses, shift on pop, append on push
    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            marked[i]      = cur_q[i];
            marked[i].done = cur_q[i].done | (gp_pulse[i] & cur_q[i].valid);
        end
        for (int i = 0; i < DEPTH; i++) begin
            if (!pop)
                nxt[i] = marked[i];
            else if (i < DEPTH - 1)
                nxt[i] = marked[(i + 1) % DEPTH];
            else
                nxt[i] = '0;
            if (push && wr_idx == CW'(i)) begin
                nxt[i].valid = 1'b1;
                nxt[i].kind  = alloc_kind;
                nxt[i].mask  = alloc_mask;
                nxt[i].drain = alloc_drain;
                nxt[i].done  = 1'b0;
            end
        end
        cnt_nxt = cnt_q - CW'(pop) + CW'(push);
    end

    // register the window and its occupancy count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q <= '0;
            cnt_q <= '0;
        end else begin
            cur_q <= nxt;
            cnt_q <= cnt_nxt;
        end
    end

    assign slots = cur_q;

    AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == CW'(DEPTH) && !pop) |=> (cnt_q == CW'(DEPTH))); // R2

    AST_BLOCKED_RETIRE: assert property (@(posedge clk) disable iff (!rst_n)
        (retire_req && cur_q[0].valid && cur_q[0].kind != OP_FENCE &&
         !cur_q[0].done && !gp_pulse[0] && !alloc_valid)
        |=> (cnt_q == $past(cnt_q) && cur_q[0].valid)); // R4

    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q[DEPTH-1].done && cur_q[DEPTH-1].valid && !pop)
        |=> cur_q[DEPTH-1].done); // R3

endmodule

// File: rtl/mem_order_rules.sv
// Combinational ordering rules: walks the window oldest to youngest,
// accumulating pending loads/stores and fence-imposed blocks.
// Assumes: slots are packed from slot 0 with no holes.
module mem_order_rules
    import mem_order_pkg::*;
#(
    parameter int unsigned DEPTH = 8
) (
    input  ord_mode_e         mode,
    input  slot_t [DEPTH-1:0] slots,
    output logic [DEPTH-1:0]  issue_ok,
    output logic [DEPTH-1:0]  fwd_ok
);
    // evaluate permissions slot by slot in program order
    always_comb begin : walk
        logic pend_ld, pend_st, blk_ld, blk_st, is_ld, is_st, ok, any_pend;
        pend_ld = 1'b0;
        pend_st = 1'b0;
        blk_ld  = 1'b0;
        blk_st  = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            is_ld = slots[i].valid && slots[i].kind == OP_LOAD;
            is_st = slots[i].valid && slots[i].kind == OP_STORE;
            case (mode)
                MD_TSO:     ok = is_ld ? !pend_ld : !(pend_ld || pend_st);
                MD_RELAXED: ok = is_ld ? !blk_ld  : !blk_st;
                default:    ok = !(pend_ld || pend_st);
            endcase
            issue_ok[i] = (is_ld || is_st) && ok;
            fwd_ok[i]   = is_ld && (mode == MD_TSO || (mode == MD_RELAXED && ok));
            if (slots[i].valid && slots[i].kind == OP_FENCE) begin
                any_pend = pend_ld || pend_st;
                blk_ld = blk_ld | (slots[i].mask[MB_LL] & pend_ld)
                                | (slots[i].mask[MB_SL] & pend_st)
                                | (slots[i].drain & any_pend);
                blk_st = blk_st | (slots[i].mask[MB_LS] & pend_ld)
                                | (slots[i].mask[MB_SS] & pend_st)
                                | (slots[i].drain & any_pend);
            end
            pend_ld = pend_ld | (is_ld & !slots[i].done);
            pend_st = pend_st | (is_st & !slots[i].done);
        end
    end

endmodule

// File: rtl/mem_order_gate.sv
// Top of the memory ordering issue gate: window storage plus rule logic.
// Assumes: mode is held constant while any entry is valid.
module mem_order_gate
    import mem_order_pkg::*;
#(
    parameter int unsigned DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       mode,
    input  logic             alloc_valid,
    input  logic [1:0]       alloc_kind,
    input  logic [3:0]       alloc_mask,
    input  logic             alloc_drain,
    input  logic             retire_req,
    input  logic [DEPTH-1:0] gp_pulse,
    output logic [DEPTH-1:0] entry_valid,
    output logic [DEPTH-1:0] issue_ok,
    output logic [DEPTH-1:0] fwd_ok
);
    slot_t [DEPTH-1:0] slots;
    logic  [DEPTH-1:0] done_vec;

    mem_order_window #(.DEPTH(DEPTH)) u_window (
        .clk         (clk),
        .rst_n       (rst_n),
        .alloc_valid (alloc_valid),
        .alloc_kind  (op_kind_e'(alloc_kind)),
        .alloc_mask  (alloc_mask),
        .alloc_drain (alloc_drain),
        .retire_req  (retire_req),
        .gp_pulse    (gp_pulse),
        .slots       (slots)
    );

    mem_order_rules #(.DEPTH(DEPTH)) u_rules (
        .mode     (ord_mode_e'(mode)),
        .slots    (slots),
        .issue_ok (issue_ok),
        .fwd_ok   (fwd_ok)
    );

    // expose occupancy and gather performed flags for the checks below
    for (genvar g = 0; g < DEPTH; g++) begin : g_flat
        assign entry_valid[g] = slots[g].valid;
        assign done_vec[g]    = slots[g].done;
    end

    AST_SEQ_ONE_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b00) |-> ($countones(issue_ok & ~done_vec) <= 1)); // R5

    AST_SEQ_NO_FWD: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b00) |-> (fwd_ok == '0)); // R6

    AST_ONLY_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        ((issue_ok | fwd_ok) & ~entry_valid) == '0); // R12

    AST_HEAD_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != 2'b10 && slots[0].valid && slots[0].kind != OP_FENCE)
        |-> issue_ok[0]); // R5

endmodule

// File: tb/mem_order_gate_test.sv
module mem_order_gate_test;
    localparam int DEPTH = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [1:0]       mode = 2'b00;
    logic             alloc_valid = 1'b0;
    logic [1:0]       alloc_kind = 2'b00;
    logic [3:0]       alloc_mask = 4'h0;
    logic             alloc_drain = 1'b0;
    logic             retire_req = 1'b0;
    logic [DEPTH-1:0] gp_pulse = '0;
    logic [DEPTH-1:0] entry_valid, issue_ok, fwd_ok;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    int         kk [DEPTH];
    logic [3:0] gg;
    logic [3:0] mm;
    logic       dd;

    always #2.5 clk = ~clk;

    mem_order_gate #(.DEPTH(DEPTH)) uut (
        .clk(clk), .rst_n(rst_n), .mode(mode), .alloc_valid(alloc_valid),
        .alloc_kind(alloc_kind), .alloc_mask(alloc_mask), .alloc_drain(alloc_drain),
        .retire_req(retire_req), .gp_pulse(gp_pulse), .entry_valid(entry_valid),
        .issue_ok(issue_ok), .fwd_ok(fwd_ok)
    );

    task automatic chk(input logic [3:0] got, input logic [3:0] exp, input string tag);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %b expected %b", tag, got, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; alloc_valid = 1'b0; retire_req = 1'b0; gp_pulse = '0;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic put(input int kind, input logic [3:0] m, input logic d);
        alloc_valid = 1'b1; alloc_kind = kind[1:0]; alloc_mask = m; alloc_drain = d;
        @(negedge clk);
        alloc_valid = 1'b0;
    endtask

    task automatic pulse(input logic [3:0] p);
        gp_pulse = p;
        @(negedge clk);
        gp_pulse = '0;
    endtask

    task automatic retire();
        retire_req = 1'b1;
        @(negedge clk);
        retire_req = 1'b0;
    endtask

    // reference permission model, written per pair of older/younger slots
    function automatic logic [3:0] ref_issue(input int md);
        logic [3:0] r = '0;
        for (int i = 0; i < DEPTH; i++) begin
            bit ok = 1'b1;
            bit pl = 1'b0, ps = 1'b0;
            if (kk[i] == 2) continue;
            for (int j = 0; j < i; j++)
                if (kk[j] != 2 && !gg[j]) begin
                    if (kk[j] == 0) pl = 1'b1; else ps = 1'b1;
                end
            if (md == 0) ok = !(pl || ps);
            else if (md == 1) ok = (kk[i] == 0) ? !pl : !(pl || ps);
            else begin
                for (int f = 0; f < i; f++) begin
                    if (kk[f] != 2) continue;
                    for (int j = 0; j < f; j++) begin
                        bit need;
                        if (kk[j] == 2 || gg[j]) continue;
                        if (kk[i] == 0) need = (kk[j] == 0) ? mm[0] : mm[2];
                        else            need = (kk[j] == 0) ? mm[1] : mm[3];
                        if (need || dd) ok = 1'b0;
                    end
                end
            end
            r[i] = ok;
        end
        return r;
    endfunction

    function automatic logic [3:0] ref_fwd(input int md, input logic [3:0] iss);
        logic [3:0] r = '0;
        for (int i = 0; i < DEPTH; i++)
            r[i] = (kk[i] == 0) && (md == 1 || (md == 2 && iss[i]));
        return r;
    endfunction

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        do_reset();
        #1;
        chk(entry_valid, 4'b0000, "R1 valid");
        chk(issue_ok,    4'b0000, "R1 issue");
        chk(fwd_ok,      4'b0000, "R1 fwd");

        // R2: fifth allocation into a full window is dropped
        mode = 2'b00;
        for (int n = 0; n < 5; n++) put(0, 4'h0, 1'b0);
        #1 chk(entry_valid, 4'b1111, "R2 full");
        pulse(4'b1111);
        for (int n = 0; n < 4; n++) retire();
        #1 chk(entry_valid, 4'b0000, "R2 fifth dropped");

        // R4: retire of unperformed head ignored; then allowed
        do_reset();
        put(1, 4'h0, 1'b0); put(0, 4'h0, 1'b0);
        retire();
        #1 chk(entry_valid, 4'b0011, "R4 held valid");
        chk(issue_ok, 4'b0001, "R4 held issue");
        pulse(4'b0001);
        retire();
        #1 chk(entry_valid, 4'b0001, "R4 popped");
        chk(issue_ok, 4'b0001, "R4 new head");

        // R4: fence head retires without being performed
        do_reset();
        put(2, 4'hF, 1'b1); put(0, 4'h0, 1'b0);
        retire();
        #1 chk(entry_valid, 4'b0001, "R4 fence pop");

        // R3: performed flags persist and shift with their entries
        do_reset();
        put(0, 4'h0, 1'b0); put(0, 4'h0, 1'b0); put(0, 4'h0, 1'b0);
        pulse(4'b0001);
        @(negedge clk); @(negedge clk);
        #1 chk(issue_ok, 4'b0011, "R3 latched");
        pulse(4'b0010);
        retire();
        #1 chk(entry_valid, 4'b0011, "R3 shift valid");
        chk(issue_ok, 4'b0011, "R3 shifted flag");

        // sweep: every kind pattern, performed pattern, mask and mode
        for (int md = 0; md < 3; md++) begin
            for (int pat = 0; pat < 81; pat++) begin
                int  v = pat;
                bit  has_f = 1'b0;
                int  n_opt;
                for (int i = 0; i < DEPTH; i++) begin
                    kk[i] = v % 3; v = v / 3;
                    if (kk[i] == 2) has_f = 1'b1;
                end
                n_opt = (md == 2 && has_f) ? 17 : 1;
                for (int g = 0; g < 16; g++) begin
                    for (int o = 0; o < n_opt; o++) begin
                        logic [3:0] ei, ef;
                        string ti, tf;
                        gg = g[3:0];
                        if (md != 2)     begin mm = 4'hF; dd = 1'b1; end
                        else if (o < 16) begin mm = o[3:0]; dd = 1'b0; end
                        else             begin mm = 4'h0; dd = 1'b1; end
                        mode = md[1:0];
                        do_reset();
                        for (int i = 0; i < DEPTH; i++) put(kk[i], mm, dd);
                        pulse(gg);
                        #1;
                        ei = ref_issue(md);
                        ef = ref_fwd(md, ei);
                        if (md == 0)      begin ti = "R5 R12 issue"; tf = "R6 fwd"; end
                        else if (md == 1) begin ti = "R7 R12 issue"; tf = "R8 fwd"; end
                        else if (!has_f)  begin ti = "R11 issue";    tf = "R11 fwd"; end
                        else if (dd)      begin ti = "R10 issue";    tf = "R11 fwd"; end
                        else              begin ti = "R9 issue";     tf = "R11 fwd"; end
                        chk(entry_valid, 4'b1111, "R2 fill");
                        chk(issue_ok, ei, ti);
                        chk(fwd_ok, ef, tf);
                    end
                end
            end
        end

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule